// File: doc/BRIEF.md
# Five-Stage Accumulator Core

This block is a small processor core built around one working register W, a carry flag, a 32-entry register bank and a 16-byte data memory. It executes a program held in an internal read-only array, given to the core as a parameter. Instructions pass through five fixed stages: fetch, decode, operand, execute and retire. Each opcode looks up exactly one microinstruction in the decode stage. That microinstruction then travels down the pipe. The operand stage uses it to pick the ALU inputs, the execute stage uses it to run the add, and the retire stage uses it to choose where the result lands.

Two register addresses face the outside world. Reading register 28 returns the external input bus. Register 30 drives the external output bus. The core has no hazard detection and no forwarding, so the program must space dependent instructions with NOPs. A jump costs one discarded fetch slot.

Top module: `acc5_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, W, carry, every pipeline stage (to NOP), the register bank and the data memory. After reset, out_bus reads 0 and the first instruction is fetched from ROM address 0.
- R2: The instruction word is 17 bits wide: opcode in [16:13], register or address field `a` in [12:8] and immediate `k` in [7:0]. The opcodes are: 0 does nothing; 1 sets W to k; 2 copies W into R[a]; 3 copies R[a] into W; 10 copies R[k[4:0]] into R[a].
- R3: Opcode 4 writes W + R[k[4:0]] + carry into R[a] and sets the carry to the carry-out of that 8-bit sum. Only the add opcodes (4, 7, 8) change the carry.
- R4: Opcode 7 adds k, read as two's complement, to W; k = 0xFF therefore decrements W. Opcode 8 adds R[a] to W without carry-in. Both set the carry to the unsigned carry-out of the 8-bit add.
- R5: Opcode 5 stores W at data memory address a[3:0]. Opcode 6 loads data memory address a[3:0] into W.
- R6: A read of register 28 returns in_bus as it stands at the operand stage of the reading instruction. out_bus always shows register 30 and changes only when an instruction retires with register 30 as its destination.
- R7: One instruction is fetched per clock and the program counter steps by one. Slot 0 is the instruction fetched on the first clock edge after reset. In straight-line code, the instruction in slot s updates its destination on the fifth edge after reset is released, counted from that slot, so out_bus shows the new value once 5 + s edges have passed.
- R8: No interlock or forwarding exists. An instruction reads its operands two edges after its fetch edge. A consumer placed 3 or more slots after its producer sees the new value. A consumer placed 1 slot after sees the old value.
- R9: Opcode 9 loads the program counter with k. The one instruction fetched behind the jump is discarded. The jump target occupies slot s + 2 when the jump is in slot s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bus | input | 8 | External input, visible as register 28 |
| out_bus | output | 8 | External output, the content of register 30 |

## Verification
The properties assume that reset is asserted for at least one edge before any check counts. They place no limit on the program contents or on in_bus, because they look only at how the program counter, W, the carry and the output register move relative to the decode and retire stages. The stimulus holds reset for several edges. It changes in_bus only on the falling edge just before the operand-stage sample edge, and it keeps the value until the next loop pass. The directed program spaces dependent instructions three slots apart, except for one pair that is deliberately placed back to back to show the stale read.

// File: rtl/acc5_pkg.sv
package acc5_pkg;
    localparam int DATA_W  = 8;
    localparam int REG_AW  = 5;
    localparam int MEM_AW  = 4;
    localparam int PC_W    = 8;
    localparam int OP_W    = 4;
    localparam int INSTR_W = OP_W + REG_AW + DATA_W;
    localparam int REG_CNT = 1 << REG_AW;
    localparam int MEM_CNT = 1 << MEM_AW;
    localparam int ROM_CNT = 1 << PC_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_MOK  = 4'd1,
        OP_WTOR = 4'd2,
        OP_RTOW = 4'd3,
        OP_ADW  = 4'd4,
        OP_STM  = 4'd5,
        OP_LDM  = 4'd6,
        OP_ADK  = 4'd7,
        OP_ADR  = 4'd8,
        OP_JMP  = 4'd9,
        OP_RTOR = 4'd10
    } opcode_e;

    typedef enum logic { A_ZERO = 1'b0, A_W = 1'b1 } asel_e;

    typedef enum logic [2:0] {
        B_ZERO = 3'd0,
        B_IMM  = 3'd1,
        B_REGA = 3'd2,
        B_REGK = 3'd3,
        B_MEM  = 3'd4
    } bsel_e;

    typedef enum logic [1:0] {
        D_NONE = 2'd0,
        D_W    = 2'd1,
        D_REG  = 2'd2,
        D_MEM  = 2'd3
    } dst_e;

    typedef struct packed {
        asel_e a_sel;
        bsel_e b_sel;
        logic  cin_en;
        dst_e  dst;
        logic  upd_cy;
    } micro_t;

    typedef struct packed {
        micro_t              uc;
        logic [REG_AW-1:0]   ra;
        logic [DATA_W-1:0]   k;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0]   a;
        logic [DATA_W-1:0]   b;
        logic                cin;
        dst_e                dst;
        logic                upd_cy;
        logic [REG_AW-1:0]   ra;
    } opr_t;

    typedef struct packed {
        logic [DATA_W-1:0]   res;
        logic                co;
        dst_e                dst;
        logic                upd_cy;
        logic [REG_AW-1:0]   ra;
    } exs_t;

    typedef struct packed {
        logic [PC_W-1:0]                 pc;
        logic [INSTR_W-1:0]              ir;
        dec_t                            dec;
        opr_t                            opr;
        exs_t                            exs;
        logic [DATA_W-1:0]               w;
        logic                            cy;
        logic [REG_CNT-1:0][DATA_W-1:0]  regs;
        logic [MEM_CNT-1:0][DATA_W-1:0]  mem;
    } core_st_t;
endpackage

// File: rtl/acc5_alu.sv
module acc5_alu
    import acc5_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              co
);
    logic [DATA_W:0] sum;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        res = sum[DATA_W-1:0];
        co  = sum[DATA_W];
    end
endmodule

// File: rtl/acc5_ucode.sv
module acc5_ucode
    import acc5_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output micro_t          uc
);
    // One microinstruction per opcode; all-zero is the idle word.
    always_comb begin
        uc = '0;
        case (op)
            OP_MOK:  begin uc.b_sel = B_IMM;  uc.dst = D_W;   end
            OP_WTOR: begin uc.a_sel = A_W;    uc.dst = D_REG; end
            OP_RTOW: begin uc.b_sel = B_REGA; uc.dst = D_W;   end
            OP_ADW:  begin
                uc.a_sel  = A_W;
                uc.b_sel  = B_REGK;
                uc.cin_en = 1'b1;
                uc.dst    = D_REG;
                uc.upd_cy = 1'b1;
            end
            OP_STM:  begin uc.a_sel = A_W;    uc.dst = D_MEM; end
            OP_LDM:  begin uc.b_sel = B_MEM;  uc.dst = D_W;   end
            OP_ADK:  begin
                uc.a_sel  = A_W;
                uc.b_sel  = B_IMM;
                uc.dst    = D_W;
                uc.upd_cy = 1'b1;
            end
            OP_ADR:  begin
                uc.a_sel  = A_W;
                uc.b_sel  = B_REGA;
                uc.dst    = D_W;
                uc.upd_cy = 1'b1;
            end
            OP_RTOR: begin uc.b_sel = B_REGK; uc.dst = D_REG; end
            default: uc = '0;
        endcase
    end
endmodule

// File: rtl/acc5_core.sv
module acc5_core
    import acc5_pkg::*;
#(
    parameter logic [REG_AW-1:0] IN_ADDR  = 5'd28,
    parameter logic [REG_AW-1:0] OUT_ADDR = 5'd30,
    parameter logic [ROM_CNT-1:0][INSTR_W-1:0] PROG = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_bus,
    output logic [DATA_W-1:0] out_bus
);
    core_st_t st_d, st_q;

    logic [OP_W-1:0]   ir_op;
    logic [REG_AW-1:0] ir_ra;
    logic [DATA_W-1:0] ir_k;
    micro_t            uc_next;
    logic [DATA_W-1:0] rd_a, rd_k;
    logic [DATA_W-1:0] alu_res;
    logic              alu_co;

    assign ir_op = st_q.ir[INSTR_W-1 -: OP_W];
    assign ir_ra = st_q.ir[DATA_W +: REG_AW];
    assign ir_k  = st_q.ir[DATA_W-1:0];

    acc5_ucode u_ucode (
        .op (ir_op),
        .uc (uc_next)
    );

    acc5_alu u_alu (
        .a   (st_q.opr.a),
        .b   (st_q.opr.b),
        .cin (st_q.opr.cin),
        .res (alu_res),
        .co  (alu_co)
    );

    // Operand-stage register reads; the input address is mapped to the bus.
    always_comb begin
        rd_a = (st_q.dec.ra == IN_ADDR) ? in_bus : st_q.regs[st_q.dec.ra];
        rd_k = (st_q.dec.k[REG_AW-1:0] == IN_ADDR) ? in_bus
                                                   : st_q.regs[st_q.dec.k[REG_AW-1:0]];
    end

    always_comb begin
        st_d = st_q;

        // fetch
        st_d.pc = st_q.pc + 1'b1;
        st_d.ir = PROG[st_q.pc];

        // decode, jump resolution
        st_d.dec.uc = uc_next;
        st_d.dec.ra = ir_ra;
        st_d.dec.k  = ir_k;
        if (ir_op == OP_JMP) begin
            st_d.pc = PC_W'(ir_k);
            st_d.ir = '0;
        end

        // operand
        st_d.opr.a = (st_q.dec.uc.a_sel == A_W) ? st_q.w : '0;
        case (st_q.dec.uc.b_sel)
            B_IMM:   st_d.opr.b = st_q.dec.k;
            B_REGA:  st_d.opr.b = rd_a;
            B_REGK:  st_d.opr.b = rd_k;
            B_MEM:   st_d.opr.b = st_q.mem[st_q.dec.ra[MEM_AW-1:0]];
            default: st_d.opr.b = '0;
        endcase
        st_d.opr.cin    = st_q.dec.uc.cin_en & st_q.cy;
        st_d.opr.dst    = st_q.dec.uc.dst;
        st_d.opr.upd_cy = st_q.dec.uc.upd_cy;
        st_d.opr.ra     = st_q.dec.ra;

        // execute
        st_d.exs.res    = alu_res;
        st_d.exs.co     = alu_co;
        st_d.exs.dst    = st_q.opr.dst;
        st_d.exs.upd_cy = st_q.opr.upd_cy;
        st_d.exs.ra     = st_q.opr.ra;

        // retire
        case (st_q.exs.dst)
            D_W:     st_d.w = st_q.exs.res;
            D_REG:   st_d.regs[st_q.exs.ra] = st_q.exs.res;
            D_MEM:   st_d.mem[st_q.exs.ra[MEM_AW-1:0]] = st_q.exs.res;
            default: ;
        endcase
        if (st_q.exs.upd_cy) begin
            st_d.cy = st_q.exs.co;
        end

        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_bus = st_q.regs[OUT_ADDR];
endmodule

// File: rtl/acc5_chk.sv
module acc5_chk
    import acc5_pkg::*;
#(
    parameter logic [REG_AW-1:0] OUT_ADDR = 5'd30
) (
    input logic              clk,
    input logic              rst,
    input logic [PC_W-1:0]   pc,
    input logic [OP_W-1:0]   ir_op,
    input logic [DATA_W-1:0] ir_k,
    input dst_e              ex_dst,
    input logic [REG_AW-1:0] ex_ra,
    input logic              ex_upd,
    input logic [DATA_W-1:0] w,
    input logic              cy,
    input logic [DATA_W-1:0] out_bus
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ir_op) != OP_JMP) |-> pc == $past(pc) + 8'd1);

    a_r9_jmp_redirect: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ir_op) == OP_JMP) |-> (pc == $past(ir_k) && ir_op == OP_NOP));

    a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
        (armed && !($past(ex_dst) == D_REG && $past(ex_ra) == OUT_ADDR)) |-> $stable(out_bus));

    a_r3_cy_hold: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(ex_upd)) |-> $stable(cy));

    a_r2_w_hold: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ex_dst) != D_W) |-> $stable(w));
endmodule

bind acc5_core acc5_chk #(.OUT_ADDR(OUT_ADDR)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (st_q.pc),
    .ir_op   (ir_op),
    .ir_k    (ir_k),
    .ex_dst  (st_q.exs.dst),
    .ex_ra   (st_q.exs.ra),
    .ex_upd  (st_q.exs.upd_cy),
    .w       (st_q.w),
    .cy      (st_q.cy),
    .out_bus (out_bus)
);

// File: tb/acc5_core_tb.sv
module acc5_core_tb;
    import acc5_pkg::*;

    localparam logic [7:0] KA = 8'd10;
    localparam logic [7:0] KB = 8'd19;
    localparam logic [7:0] KC = 8'hF0;
    localparam logic [7:0] KD = 8'h20;
    localparam int         LOOPS = 200;

    function automatic logic [INSTR_W-1:0] ins(logic [3:0] op, logic [4:0] a, logic [7:0] k);
        return {op, a, k};
    endfunction

    // Straight-line code spaced three slots apart, then a copy loop.
    function automatic logic [ROM_CNT-1:0][INSTR_W-1:0] build_prog();
        logic [ROM_CNT-1:0][INSTR_W-1:0] p;
        p = '0;
        p[0]  = ins(OP_MOK,  5'd0,  KA);
        p[3]  = ins(OP_WTOR, 5'd30, 8'd0);
        p[6]  = ins(OP_WTOR, 5'd0,  8'd0);
        p[9]  = ins(OP_MOK,  5'd0,  KB);
        p[12] = ins(OP_ADW,  5'd1,  8'd0);
        p[15] = ins(OP_RTOR, 5'd30, 8'd1);
        p[18] = ins(OP_RTOW, 5'd1,  8'd0);
        p[21] = ins(OP_STM,  5'd3,  8'd0);
        p[24] = ins(OP_MOK,  5'd0,  KC);
        p[27] = ins(OP_ADK,  5'd0,  KD);
        p[30] = ins(OP_ADW,  5'd2,  8'd0);
        p[33] = ins(OP_RTOR, 5'd30, 8'd2);
        p[36] = ins(OP_LDM,  5'd3,  8'd0);
        p[39] = ins(OP_WTOR, 5'd30, 8'd0);
        p[42] = ins(OP_ADK,  5'd0,  8'hFF);
        p[45] = ins(OP_WTOR, 5'd30, 8'd0);
        p[48] = ins(OP_ADR,  5'd0,  8'd0);
        p[51] = ins(OP_RTOR, 5'd30, 8'd0);
        p[54] = ins(OP_MOK,  5'd0,  8'h55);
        p[55] = ins(OP_WTOR, 5'd30, 8'd0);
        p[57] = ins(OP_WTOR, 5'd30, 8'd0);
        p[60] = ins(OP_JMP,  5'd0,  8'd64);
        p[61] = ins(OP_RTOR, 5'd30, 8'd1);
        p[62] = ins(OP_MOK,  5'd0,  8'h99);
        p[63] = ins(OP_WTOR, 5'd30, 8'd0);
        p[64] = ins(OP_RTOR, 5'd30, 8'd28);
        p[65] = ins(OP_JMP,  5'd0,  8'd64);
        p[66] = ins(OP_RTOR, 5'd30, 8'd0);
        return p;
    endfunction

    localparam logic [ROM_CNT-1:0][INSTR_W-1:0] TB_PROG = build_prog();

    function automatic logic [8:0] add8(logic [7:0] a, logic [7:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {8'd0, c};
    endfunction

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_bus = 8'd0;
    logic [7:0] out_bus;
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    acc5_core #(.PROG(TB_PROG)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .in_bus  (in_bus),
        .out_bus (out_bus)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s out_bus=%0h expected=%0h at cyc %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] s_ab, s_cd, s_r2, s_dec, s_adr;
        logic [7:0] v, v_prev;
        v      = $urandom(32'd4711);
        v_prev = 8'd0;
        s_ab  = add8(KB, KA, 1'b0);
        s_cd  = add8(KC, KD, 1'b0);
        s_r2  = add8(s_cd[7:0], KA, s_cd[8]);
        s_dec = add8(s_ab[7:0], 8'hFF, 1'b0);
        s_adr = add8(s_dec[7:0], KA, 1'b0);

        repeat (4) @(negedge clk);
        chk("R1 reset", out_bus, 8'd0);
        rst = 1'b0;
        wait_cyc(7);
        chk("R7 no write before slot timing", out_bus, 8'd0);
        wait_cyc(8);
        chk("R2 MOK then W to reg", out_bus, KA);
        wait_cyc(19);
        chk("R6 out holds between writes", out_bus, KA);
        wait_cyc(20);
        chk("R3 ADW sum via reg copy R2", out_bus, s_ab[7:0]);
        wait_cyc(38);
        chk("R3 ADW uses carry from ADK", out_bus, s_r2[7:0]);
        wait_cyc(44);
        chk("R5 memory store and load", out_bus, s_ab[7:0]);
        wait_cyc(50);
        chk("R4 ADK minus one", out_bus, s_dec[7:0]);
        wait_cyc(56);
        chk("R2 reg to reg copy", out_bus, KA);
        wait_cyc(60);
        chk("R8 stale W read, R4 ADR sum", out_bus, s_adr[7:0]);
        wait_cyc(62);
        chk("R8 W visible three slots later", out_bus, 8'h55);

        for (int m = 0; m < LOOPS; m++) begin
            wait_cyc(64 + 3 * m);
            if (m > 0) chk("R6 input copied to output", out_bus, v_prev);
            v = (m < 2) ? ((m == 0) ? 8'hFF : 8'h00) : 8'($urandom());
            in_bus = v;
            wait_cyc(66 + 3 * m);
            if (m == 0) chk("R9 slot behind jump discarded", out_bus, 8'h55);
            else        chk("R9 loop flush slot", out_bus, v_prev);
            v_prev = v;
        end
        wait_cyc(64 + 3 * LOOPS);
        chk("R6 last input copy", out_bus, v_prev);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule